// File: doc/BRIEF.md
# Input Level Detector with Dwell Release

This block watches a stream of ADC samples and drives indicator outputs that switch a front-end attenuator or gain stage. When a sample reaches the upper threshold, the indicator turns on at once. It turns off only after the signal has stayed at or below the lower threshold for a programmed number of consecutive valid samples. If the signal climbs back above the lower threshold before that count runs out, the count restarts, which gives the indicator hysteresis.

Two identical detector ports (A and B) are provided. Each port has its own sample stream, its own channel-select input and its own four write-only registers: lower threshold, upper threshold, dwell length and configuration. The configuration word sets the active level of the indicator and an extra output delay of 0 to 7 cycles, which covers converter and gain-settling latency. It also selects between a single-source mode and a multiplexed mode. In single-source mode, output 0 carries the indicator and output 1 carries its complement. In multiplexed mode, the select input that accompanies each sample steers the indicator to output 0 or to output 1.

Top module: `lvl_detector`

## Requirements
- R1: On a valid sample whose 10 most significant bits, read as unsigned, are greater than or equal to the upper threshold (and with a nonzero dwell), the detector becomes active.
- R2: A valid sample whose top 10 bits are strictly between the two thresholds leaves an active detector active. A sample whose top 10 bits equal the lower threshold counts as low.
- R3: With dwell value N (N ≥ 1), an active detector goes inactive on the Nth consecutive valid low sample that follows an upper excursion.
- R4: A valid sample above the lower threshold that arrives while the detector is dwelling restarts the count, so N further low samples are needed.
- R5: A valid sample at or above the upper threshold that arrives while the detector is dwelling keeps the detector active and also restarts the count.
- R6: While the dwell register is zero, the detector is held inactive. It is forced inactive on the cycle after zero is written, and upper-threshold samples do not activate it.
- R7: Configuration bit 4 sets the active level. When it is 0, an output is 1 while active. When it is 1, an output is 0 while active and 1 while inactive.
- R8: When configuration bit 3 is 0 (single-source mode), output 0 carries the indicator and output 1 is always its complement.
- R9: When configuration bit 3 is 1 (multiplexed mode), the select value captured with each valid sample routes the indicator to output 0 (select 0) or output 1 (select 1). The other output stays at the inactive level.
- R10: With configuration bits 2:0 equal to D, the indicator outputs change 1+D clock cycles after the edge that captures the deciding sample.
- R11: Register write address bits 1:0 pick the register (0 lower threshold, 1 upper threshold, 2 dwell, 3 configuration), and bit 2 picks the port (0 is A, 1 is B). A write to one port leaves the other port's registers and detection unchanged.
- R12: After reset, all registers are zero and each port is inactive, so output 0 is 0 and output 1 is 1.
- R13: Samples presented while the valid strobe is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: bit 2 selects the port, bits 1:0 select the register |
| wrData | input | 20 | Write data; thresholds use bits 9:0, configuration uses bits 4:0 |
| smpValidA | input | 1 | Sample valid for port A |
| smpDataA | input | 14 | Port A sample |
| chanSelA | input | 1 | Port A source select, captured with valid samples |
| smpValidB | input | 1 | Sample valid for port B |
| smpDataB | input | 14 | Port B sample |
| chanSelB | input | 1 | Port B source select, captured with valid samples |
| indPortA | output | 2 | Port A indicators: bit 0 is output 0, bit 1 is output 1 |
| indPortB | output | 2 | Port B indicators: bit 0 is output 0, bit 1 is output 1 |

## Verification
The assertions assume that reset is applied before any sample or write, that sample data is stable in every cycle where its valid strobe is high, and that the configuration word stays fixed while an indicator change is still passing through the delay line. The upper threshold is always programmed above the lower one. The directed stimulus drives every input on the falling clock edge and holds valid high for exactly one cycle per sample. Each test reprograms the registers only between scenarios, after a reset, and never while a sample is in flight.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

  // Strobes handed from detection control to the output datapath.
  typedef struct packed {
    logic active;  // level detector currently asserted
    logic route;   // select value captured with the last valid sample
  } lvlFlags_t;

  // Register index within one port (address bits 1:0).
  typedef enum logic [1:0] {
    REG_LOW   = 2'd0,
    REG_UP    = 2'd1,
    REG_DWELL = 2'd2,
    REG_CFG   = 2'd3
  } lvlReg_e;

endpackage

// File: rtl/lvl_regs.sv
module lvl_regs
  import lvl_pkg::*;
#(
  parameter int THR_W   = 10,
  parameter int DWELL_W = 20,
  parameter int CFG_W   = 5,
  parameter int PORT_ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [DWELL_W-1:0] wrData,
  output logic [THR_W-1:0]   lowThr,
  output logic [THR_W-1:0]   upThr,
  output logic [DWELL_W-1:0] dwell,
  output logic [CFG_W-1:0]   cfg
);

  localparam logic PORT_BIT = PORT_ID[0];

  logic hit;
  assign hit = wrEn && (wrAddr[2] == PORT_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      lowThr <= '0;
      upThr  <= '0;
      dwell  <= '0;
      cfg    <= '0;
    end else if (hit) begin
      case (lvlReg_e'(wrAddr[1:0]))
        REG_LOW:   lowThr <= wrData[THR_W-1:0];
        REG_UP:    upThr  <= wrData[THR_W-1:0];
        REG_DWELL: dwell  <= wrData;
        REG_CFG:   cfg    <= wrData[CFG_W-1:0];
        default:   ;
      endcase
    end
  end

  // R11: a write aimed at the other port leaves this port's registers untouched
  assert_other_port_R11: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr[2] != PORT_BIT) |=>
      ($stable(lowThr) && $stable(upThr) && $stable(dwell) && $stable(cfg)));

endmodule

// File: rtl/lvl_ctrl.sv
module lvl_ctrl
  import lvl_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 10,
  parameter int DWELL_W  = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smpValid,
  input  logic [SAMPLE_W-1:0] smpData,
  input  logic                chanSel,
  input  logic [THR_W-1:0]    lowThr,
  input  logic [THR_W-1:0]    upThr,
  input  logic [DWELL_W-1:0]  dwell,
  output lvlFlags_t           flags
);

  localparam int LSB_W = SAMPLE_W - THR_W;

  // Comparing the full sample against padded thresholds is the same as
  // comparing its top THR_W bits against the thresholds themselves.
  logic [SAMPLE_W-1:0] upEdge, lowEdge;
  assign upEdge  = {upThr,  {LSB_W{1'b0}}};
  assign lowEdge = {lowThr, {LSB_W{1'b1}}};

  logic upMet, lowMet, enabled;
  assign upMet   = smpData >= upEdge;
  assign lowMet  = smpData <= lowEdge;
  assign enabled = dwell != '0;

  logic               active, dwelling, route;
  logic [DWELL_W-1:0] cnt, nextCnt;

  assign nextCnt = dwelling ? (cnt - 1'b1) : (dwell - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      dwelling <= 1'b0;
      cnt      <= '0;
      route    <= 1'b0;
    end else if (!enabled) begin
      active   <= 1'b0;
      dwelling <= 1'b0;
      cnt      <= '0;
    end else if (smpValid) begin
      route <= chanSel;
      if (upMet) begin
        active   <= 1'b1;
        dwelling <= 1'b0;
      end else if (active) begin
        if (lowMet) begin
          if (nextCnt == '0) begin
            active   <= 1'b0;
            dwelling <= 1'b0;
            cnt      <= '0;
          end else begin
            cnt      <= nextCnt;
            dwelling <= 1'b1;
          end
        end else begin
          dwelling <= 1'b0;
        end
      end
    end
  end

  assign flags.active = active;
  assign flags.route  = route;

  // R1: an upper-threshold sample activates the detector
  assert_upper_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (smpValid && enabled && upMet) |=> flags.active);

  // R2: a sample between the thresholds never releases the detector
  assert_mid_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (smpValid && enabled && flags.active && !upMet && !lowMet) |=> flags.active);

  // R6: a zero dwell keeps the detector inactive
  assert_dwell_off_R6: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> !flags.active);

  // R3: release only on a valid low sample or a disabling dwell value
  assert_release_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(flags.active) |-> $past(!enabled || (smpValid && lowMet && !upMet)));

  // R13: without a valid strobe the detector state does not move
  assert_idle_stable_R13: assert property (@(posedge clk) disable iff (rst)
    (!smpValid && enabled) |=> $stable(flags.active));

endmodule

// File: rtl/lvl_dpath.sv
module lvl_dpath
  import lvl_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  lvlFlags_t        flags,
  input  logic [DLY_W+1:0] cfg,
  output logic             indOut0,
  output logic             indOut1
);

  localparam int DEPTH   = (1 << DLY_W) - 1;
  localparam int MUX_BIT = DLY_W;
  localparam int POL_BIT = DLY_W + 1;

  lvlFlags_t taps [0:DEPTH];
  assign taps[0] = flags;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) taps[i+1] <= '0;
      else     taps[i+1] <= taps[i];
    end
  end

  lvlFlags_t picked;
  assign picked = taps[cfg[DLY_W-1:0]];

  logic pol, muxMode, lvl0, lvl1;
  assign pol     = cfg[POL_BIT];
  assign muxMode = cfg[MUX_BIT];

  always_comb begin
    if (muxMode) begin
      lvl0 = picked.active & ~picked.route;
      lvl1 = picked.active &  picked.route;
    end else begin
      lvl0 = picked.active;
      lvl1 = ~picked.active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      indOut0 <= 1'b0;
      indOut1 <= 1'b1;
    end else begin
      indOut0 <= lvl0 ^ pol;
      indOut1 <= lvl1 ^ pol;
    end
  end

  // R8: in single-source mode the second output is the complement
  assert_single_compl_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg[MUX_BIT]) |-> (indOut1 == ~indOut0));

  // R9: in multiplexed mode at most one output is at the active level
  assert_mux_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cfg[MUX_BIT]) |->
      !((indOut0 ^ $past(cfg[POL_BIT])) && (indOut1 ^ $past(cfg[POL_BIT]))));

endmodule

// File: rtl/lvl_detector.sv
module lvl_detector
  import lvl_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int THR_W    = 10,
  parameter int DWELL_W  = 20,
  parameter int DLY_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [DWELL_W-1:0]  wrData,
  input  logic                smpValidA,
  input  logic [SAMPLE_W-1:0] smpDataA,
  input  logic                chanSelA,
  input  logic                smpValidB,
  input  logic [SAMPLE_W-1:0] smpDataB,
  input  logic                chanSelB,
  output logic [1:0]          indPortA,
  output logic [1:0]          indPortB
);

  localparam int CFG_W  = DLY_W + 2;
  localparam int NPORTS = 2;

  logic                smpValid [NPORTS];
  logic [SAMPLE_W-1:0] smpData  [NPORTS];
  logic                chanSel  [NPORTS];
  logic [1:0]          indOut   [NPORTS];

  assign smpValid[0] = smpValidA;
  assign smpValid[1] = smpValidB;
  assign smpData[0]  = smpDataA;
  assign smpData[1]  = smpDataB;
  assign chanSel[0]  = chanSelA;
  assign chanSel[1]  = chanSelB;
  assign indPortA    = indOut[0];
  assign indPortB    = indOut[1];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [THR_W-1:0]   lowThr, upThr;
    logic [DWELL_W-1:0] dwell;
    logic [CFG_W-1:0]   cfg;
    lvlFlags_t          flags;

    lvl_regs #(
      .THR_W(THR_W), .DWELL_W(DWELL_W), .CFG_W(CFG_W), .PORT_ID(p)
    ) u_regs (
      .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
      .lowThr(lowThr), .upThr(upThr), .dwell(dwell), .cfg(cfg)
    );

    lvl_ctrl #(
      .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .DWELL_W(DWELL_W)
    ) u_ctrl (
      .clk(clk), .rst(rst), .smpValid(smpValid[p]), .smpData(smpData[p]),
      .chanSel(chanSel[p]), .lowThr(lowThr), .upThr(upThr), .dwell(dwell),
      .flags(flags)
    );

    lvl_dpath #(
      .DLY_W(DLY_W)
    ) u_dpath (
      .clk(clk), .rst(rst), .flags(flags), .cfg(cfg),
      .indOut0(indOut[p][0]), .indOut1(indOut[p][1])
    );
  end

endmodule

// File: tb/tb_lvl_detector.sv
`timescale 1ns/1ps
module tb_lvl_detector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [19:0] wrData = '0;
  logic        smpValidA = 1'b0, smpValidB = 1'b0;
  logic [13:0] smpDataA = '0, smpDataB = '0;
  logic        chanSelA = 1'b0, chanSelB = 1'b0;
  logic [1:0]  indPortA, indPortB;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lvl_detector dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .smpValidA(smpValidA), .smpDataA(smpDataA), .chanSelA(chanSelA),
    .smpValidB(smpValidB), .smpDataB(smpDataB), .chanSelB(chanSelB),
    .indPortA(indPortA), .indPortB(indPortB)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Program one port: port 0 is A, port 1 is B (address bit 2)
  task automatic prog(input int port, input int low, input int up, input int dw, input int cf);
    wr({port[0], 2'd0}, 20'(low));
    wr({port[0], 2'd1}, 20'(up));
    wr({port[0], 2'd2}, 20'(dw));
    wr({port[0], 2'd3}, 20'(cf));
  endtask

  // One valid sample whose top 10 bits are 'top'; returns one cycle later
  task automatic smp(input int port, input int top, input logic sel);
    if (port == 0) begin
      smpValidA = 1'b1; smpDataA = {10'(top), 4'h7}; chanSelA = sel;
    end else begin
      smpValidB = 1'b1; smpDataB = {10'(top), 4'h7}; chanSelB = sel;
    end
    @(negedge clk);
    smpValidA = 1'b0; smpValidB = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R12 reset port A", indPortA, 2'b10);
    chk("R12 reset port B", indPortB, 2'b10);
  endtask

  task automatic testDwell();
    doReset();
    prog(0, 100, 500, 3, 0);
    smp(0, 499, 0); idle(1);
    chk("R1 below upper", indPortA, 2'b10);
    smp(0, 500, 0); idle(1);
    chk("R1 upper equal asserts", indPortA, 2'b01);
    chk("R8 complement", {indPortA[1], indPortA[0]}, {~indPortA[0], indPortA[0]});
    smp(0, 300, 0); idle(1);
    chk("R2 mid holds", indPortA, 2'b01);
    smp(0, 100, 0); smp(0, 100, 0); idle(1);
    chk("R2 two low held", indPortA, 2'b01);
    smp(0, 300, 0);
    smp(0, 50, 0); smp(0, 50, 0); idle(1);
    chk("R4 reload after rise", indPortA, 2'b01);
    smp(0, 50, 0); idle(1);
    chk("R3 release on third low", indPortA, 2'b10);
  endtask

  task automatic testUpperReload();
    doReset();
    prog(0, 100, 500, 3, 0);
    smp(0, 600, 0); smp(0, 10, 0); smp(0, 10, 0);
    smp(0, 700, 0); smp(0, 10, 0); smp(0, 10, 0); idle(1);
    chk("R5 upper reload holds", indPortA, 2'b01);
    smp(0, 10, 0); idle(1);
    chk("R5 release after restart", indPortA, 2'b10);
  endtask

  task automatic testNoValid();
    doReset();
    prog(0, 100, 500, 1, 0);
    smpDataA = 14'h3FFF; idle(5);
    chk("R13 high data no valid", indPortA, 2'b10);
    smp(0, 600, 0);
    smpDataA = '0; idle(8);
    chk("R13 low data no valid", indPortA, 2'b01);
  endtask

  task automatic testDisable();
    doReset();
    prog(0, 100, 500, 4, 0);
    smp(0, 600, 0); idle(1);
    chk("R6 active before disable", indPortA, 2'b01);
    wr(3'd2, 20'd0); idle(2);
    chk("R6 zero dwell forces off", indPortA, 2'b10);
    smp(0, 900, 0); idle(1);
    chk("R6 upper ignored when disabled", indPortA, 2'b10);
  endtask

  task automatic testPolarity();
    doReset();
    prog(0, 100, 500, 1, 16);
    idle(1);
    chk("R7 inactive level high", indPortA, 2'b01);
    smp(0, 600, 0); idle(1);
    chk("R7 active low", indPortA, 2'b10);
    smp(0, 0, 0); idle(1);
    chk("R7 released", indPortA, 2'b01);
  endtask

  task automatic testMux();
    doReset();
    prog(0, 100, 500, 1, 8);
    smp(0, 600, 1); idle(1);
    chk("R9 select 1 to output 1", indPortA, 2'b10);
    smp(0, 0, 1); idle(1);
    chk("R9 release both idle", indPortA, 2'b00);
    smp(0, 600, 0); idle(1);
    chk("R9 select 0 to output 0", indPortA, 2'b01);
    wr(3'd3, 20'd24); idle(1);
    chk("R9 R7 inverted routing", indPortA, 2'b10);
    smp(0, 0, 0); idle(1);
    chk("R9 R7 inverted idle", indPortA, 2'b11);
  endtask

  task automatic testDelay();
    doReset();
    prog(0, 100, 500, 1, 3);
    smp(0, 600, 0); idle(3);
    chk("R10 not yet after 3", indPortA, 2'b10);
    idle(1);
    chk("R10 visible after 1+3", indPortA, 2'b01);
    smp(0, 0, 0); idle(3);
    chk("R10 release pending", indPortA, 2'b01);
    idle(1);
    chk("R10 release visible", indPortA, 2'b10);
  endtask

  task automatic testPorts();
    doReset();
    prog(1, 100, 500, 1, 0);
    smp(1, 600, 0); idle(1);
    chk("R11 port B active", indPortB, 2'b01);
    chk("R11 port A untouched", indPortA, 2'b10);
    prog(0, 200, 1000, 1, 16);
    smp(0, 600, 0); idle(1);
    chk("R11 port A below own upper", indPortA, 2'b01);
    chk("R11 port B unchanged", indPortB, 2'b01);
    smp(1, 0, 0); idle(1);
    chk("R11 port B release", indPortB, 2'b10);
  endtask

  initial begin
    testReset();
    testDwell();
    testUpperReload();
    testNoValid();
    testDisable();
    testPolarity();
    testMux();
    testDelay();
    testPorts();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule